// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It walks a two-level page table held in ordinary memory. A request carries the logical address, the kind of access (write or read, user or supervisor) and the physical base of the first-level table.

The walker makes at most two dependent reads through a simple read port: a one-cycle request pulse with an address, and later a one-cycle response-valid with the data. It then reports one of two outcomes in a single cycle:
- the translated address together with the fields of the final table entry, or
- a fault code.

Pages are 8 KB. The top 10 address bits index the first-level table, the next 9 bits index the second-level table, and the low 13 bits are the byte offset. Table entries are 32 bits wide (4 bytes apart in memory) and use this layout:
- bit 0: present flag
- bit 1: referenced flag
- bit 2: dirty flag
- bits 4:3: access rights (bit 3 = writes allowed, bit 4 = user access allowed)
- bits 12:5: reserved
- bits 31:13: a 19-bit frame number

In a first-level entry, the frame number is the 8 KB-aligned base of the second-level table. In a second-level entry, it is the physical frame of the page.

Top module: `ptw_two_level`

## Requirements
- R1: On a walk with no fault, the result address is the second-level frame number in bits 31:13 with the request's low 13 bits placed below it unchanged.
- R2: The first read of each walk goes to the table base input plus four times logical bits 31:22.
- R3: The second read goes to the first-level frame number followed by 13 zero bits, plus four times logical bits 21:13.
- R4: If the first-level entry has bit 0 clear, the walk ends with fault code 1 and no second read is issued.
- R5: If the second-level entry has bit 0 clear, the walk ends with fault code 2.
- R6: With a present second-level entry, a write to a page whose bit 3 is clear, or a user access to a page whose bit 4 is clear, ends with fault code 3. The access bits of the first-level entry have no effect.
- R7: Fault code 0 means success. With any non-zero code the result address is zero. The reported frame, referenced, dirty and access fields come from the last entry read.
- R8: Only one memory read is outstanding at a time. Requests are accepted only while the ready output is high, which holds only when the walker is idle. A request offered while busy is ignored.
- R9: During and right after reset the walker is idle: ready high, no memory request, no completion.
- R10: The completion strobe is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| ptbr | input | 32 | Physical base of the first-level table, sampled at acceptance |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Physical byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid (one cycle, after the request) |
| mem_rdata | input | 32 | Table entry read from memory |
| done | output | 1 | One-cycle completion strobe |
| done_fault | output | 2 | 0 ok, 1 first level absent, 2 second level absent, 3 access denied |
| done_paddr | output | 32 | Translated physical address (zero on fault) |
| done_frame | output | 19 | Frame number of the last entry read |
| done_ref | output | 1 | Referenced flag of the last entry read |
| done_dirty | output | 1 | Dirty flag of the last entry read |
| done_prot | output | 2 | Access bits of the last entry read |

## Verification
The bench builds the walker with its default split of 10, 9 and 13 bits and 32-bit entries. With these values a behavioural memory can hold many first-level slots, each pointing to its own second-level table, including the top index of both levels and the all-ones offset. Memory latency is drawn per walk from one to four cycles, so the waiting states are exercised with different lengths. Directed walks cover:
- each fault code;
- a first-level entry with no access rights over a fully open page;
- requests offered while a walk is in progress.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Fixed entry layout: the walker decodes these positions
  localparam int PTE_PRESENT = 0;
  localparam int PTE_REF     = 1;
  localparam int PTE_DIRTY   = 2;
  localparam int PTE_ACC_LO  = 3;
  localparam int PTE_ACC_W   = 2;
  localparam int PTE_LOW_W   = PTE_ACC_LO + PTE_ACC_W;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_L1_ABS = 2'd1,
    FLT_L2_ABS = 2'd2,
    FLT_ACCESS = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_W1, ST_RD2, ST_W2, ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_entry_unpack.sv
module ptw_entry_unpack
  import ptw_pkg::*;
#(
  parameter int ENTRY_W = 32,
  parameter int FRAME_W = 19
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic               present,
  output logic               refd,
  output logic               dirty,
  output logic [PTE_ACC_W-1:0] acc,
  output logic [FRAME_W-1:0] frame
);
  localparam int RSVD_W = ENTRY_W - FRAME_W - PTE_LOW_W;

  assign present = entry[PTE_PRESENT];
  assign refd    = entry[PTE_REF];
  assign dirty   = entry[PTE_DIRTY];
  assign acc     = entry[PTE_ACC_LO +: PTE_ACC_W];
  assign frame   = entry[ENTRY_W-1 -: FRAME_W];

  generate
    if (RSVD_W > 0) begin : g_rsvd
      logic rsvd_unused;
      assign rsvd_unused = ^entry[PTE_LOW_W +: RSVD_W];
    end
  endgenerate
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W   = 32,
  parameter int L1_W   = 10,
  parameter int L2_W   = 9,
  parameter int OFF_W  = 13,
  parameter int ENT_LG = 2
) (
  input  logic                    second,
  input  logic [PA_W-1:0]         tbl_base,
  input  logic [PA_W-OFF_W-1:0]   l1_frame,
  input  logic [L1_W-1:0]         l1_idx,
  input  logic [L2_W-1:0]         l2_idx,
  output logic [PA_W-1:0]         addr
);
  logic [PA_W-1:0] base_sel;
  logic [PA_W-1:0] step;

  always_comb begin
    if (second) begin
      base_sel = {l1_frame, {OFF_W{1'b0}}};
      step     = PA_W'(l2_idx) << ENT_LG;
    end else begin
      base_sel = tbl_base;
      step     = PA_W'(l1_idx) << ENT_LG;
    end
    addr = base_sel + step;
  end
endmodule

// File: rtl/ptw_access_check.sv
module ptw_access_check
  import ptw_pkg::*;
(
  input  logic                 is_write,
  input  logic                 is_user,
  input  logic [PTE_ACC_W-1:0] acc,
  output logic                 deny
);
  // acc[0]: writes allowed, acc[1]: user access allowed
  assign deny = (is_write && !acc[0]) || (is_user && !acc[1]);
endmodule

// File: rtl/ptw_two_level.sv
module ptw_two_level
  import ptw_pkg::*;
#(
  parameter int L1_W    = 10,
  parameter int L2_W    = 9,
  parameter int OFF_W   = 13,
  parameter int PA_W    = 32,
  parameter int ENTRY_W = 32,
  parameter int ENT_LG  = 2,
  localparam int VA_W   = L1_W + L2_W + OFF_W,
  localparam int FRAME_W = PA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [PA_W-1:0]    ptbr,
  output logic               mem_req,
  output logic [PA_W-1:0]    mem_addr,
  input  logic               mem_rvalid,
  input  logic [ENTRY_W-1:0] mem_rdata,
  output logic               done,
  output logic [1:0]         done_fault,
  output logic [PA_W-1:0]    done_paddr,
  output logic [FRAME_W-1:0] done_frame,
  output logic               done_ref,
  output logic               done_dirty,
  output logic [1:0]         done_prot
);
  // reset synchroniser: assert asynchronously, release on clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  walk_st_e st_q, st_d;
  logic [VA_W-1:0]    va_q;
  logic               wr_q, usr_q;
  logic [PA_W-1:0]    base_q;
  logic [FRAME_W-1:0] l1f_q;
  fault_e             flt_q, flt_d;
  logic [PA_W-1:0]    pa_q, pa_d;
  logic [FRAME_W-1:0] frm_q;
  logic               ref_q, dty_q;
  logic [PTE_ACC_W-1:0] acc_q;

  logic accept, resp1, resp2, res_en;
  logic e_present, e_ref, e_dirty, e_deny;
  logic [PTE_ACC_W-1:0] e_acc;
  logic [FRAME_W-1:0]   e_frame;

  ptw_entry_unpack #(.ENTRY_W(ENTRY_W), .FRAME_W(FRAME_W)) u_unpack (
    .entry(mem_rdata), .present(e_present), .refd(e_ref), .dirty(e_dirty),
    .acc(e_acc), .frame(e_frame)
  );

  ptw_access_check u_acc (
    .is_write(wr_q), .is_user(usr_q), .acc(e_acc), .deny(e_deny)
  );

  ptw_addr_gen #(
    .PA_W(PA_W), .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W), .ENT_LG(ENT_LG)
  ) u_agen (
    .second(st_q == ST_RD2), .tbl_base(base_q), .l1_frame(l1f_q),
    .l1_idx(va_q[VA_W-1 -: L1_W]), .l2_idx(va_q[OFF_W +: L2_W]),
    .addr(mem_addr)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign resp1     = (st_q == ST_W1) && mem_rvalid;
  assign resp2     = (st_q == ST_W2) && mem_rvalid;
  assign mem_req   = (st_q == ST_RD1) || (st_q == ST_RD2);

  // next-state and result selection
  always_comb begin
    st_d   = st_q;
    flt_d  = FLT_NONE;
    pa_d   = '0;
    res_en = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_RD1;
      ST_RD1:  st_d = ST_W1;
      ST_W1: if (mem_rvalid) begin
        if (e_present) begin
          st_d = ST_RD2;
        end else begin
          st_d   = ST_DONE;
          flt_d  = FLT_L1_ABS;
          res_en = 1'b1;
        end
      end
      ST_RD2:  st_d = ST_W2;
      ST_W2: if (mem_rvalid) begin
        st_d   = ST_DONE;
        res_en = 1'b1;
        if (!e_present)  flt_d = FLT_L2_ABS;
        else if (e_deny) flt_d = FLT_ACCESS;
        else             pa_d  = {e_frame, va_q[OFF_W-1:0]};
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      va_q   <= req_vaddr;
      wr_q   <= req_write;
      usr_q  <= req_user;
      base_q <= ptbr;
    end
    if (resp1) l1f_q <= e_frame;
    if (res_en) begin
      flt_q <= flt_d;
      pa_q  <= pa_d;
      frm_q <= e_frame;
      ref_q <= e_ref;
      dty_q <= e_dirty;
      acc_q <= e_acc;
    end
  end

  logic resp2_unused;
  assign resp2_unused = resp2;

  assign done       = (st_q == ST_DONE);
  assign done_fault = flt_q;
  assign done_paddr = pa_q;
  assign done_frame = frm_q;
  assign done_ref   = ref_q;
  assign done_dirty = dty_q;
  assign done_prot  = acc_q;
endmodule

// File: rtl/ptw_two_level_chk.sv
module ptw_two_level_chk #(
  parameter int L1_W   = 10,
  parameter int L2_W   = 9,
  parameter int OFF_W  = 13,
  parameter int PA_W   = 32,
  parameter int ENT_LG = 2,
  localparam int VA_W  = L1_W + L2_W + OFF_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic [PA_W-1:0] ptbr,
  input logic            mem_req,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_rvalid,
  input logic            done,
  input logic [1:0]      done_fault,
  input logic [PA_W-1:0] done_paddr
);
  logic            pend_q;
  logic [1:0]      nrd_q;
  logic [VA_W-1:0] va_c;
  logic [PA_W-1:0] base_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      nrd_q  <= '0;
      va_c   <= '0;
      base_c <= '0;
    end else begin
      if (mem_req)         pend_q <= 1'b1;
      else if (mem_rvalid) pend_q <= 1'b0;
      if (req_valid && req_ready) begin
        nrd_q  <= '0;
        va_c   <= req_vaddr;
        base_c <= ptbr;
      end else if (mem_req) begin
        nrd_q <= nrd_q + 2'd1;
      end
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pend_q); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8
  AST_FIRST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && nrd_q == 2'd0) |->
      mem_addr == base_c + (PA_W'(va_c[VA_W-1 -: L1_W]) << ENT_LG)); // R2
  AST_L1_ABSENT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault == 2'd1) |-> nrd_q == 2'd1); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault == 2'd0) |->
      done_paddr[OFF_W-1:0] == va_c[OFF_W-1:0]); // R1
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault != 2'd0) |-> done_paddr == '0); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !done); // R9
endmodule

bind ptw_two_level ptw_two_level_chk #(
  .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W), .PA_W(PA_W), .ENT_LG(ENT_LG)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .ptbr(ptbr), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .done(done), .done_fault(done_fault),
  .done_paddr(done_paddr)
);

// File: tb/ptw_two_level_bench.sv
module ptw_two_level_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TBL = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0, ptbr = TBL;
  logic req_ready, mem_req, mem_rvalid, done, done_ref, done_dirty;
  logic [31:0] mem_addr, mem_rdata, done_paddr;
  logic [1:0] done_fault, done_prot;
  logic [18:0] done_frame;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_two_level u_ptw_two_level (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .ptbr(ptbr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
    .done_fault(done_fault), .done_paddr(done_paddr), .done_frame(done_frame),
    .done_ref(done_ref), .done_dirty(done_dirty), .done_prot(done_prot)
  );

  // behavioural memory with a per-walk latency
  logic [31:0] pmem [logic [31:0]];
  int unsigned lat = 1;
  int unsigned cnt_q = 0, rd_total = 0;
  logic pend_q = 1'b0;
  logic [31:0] pa_q = '0, rd_last = '0, rd_prev = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      pend_q   <= 1'b1;
      cnt_q    <= lat - 1;
      pa_q     <= mem_addr;
      rd_total <= rd_total + 1;
      rd_prev  <= rd_last;
      rd_last  <= mem_addr;
    end else if (pend_q) begin
      if (cnt_q == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(pa_q);
        pend_q     <= 1'b0;
      end else cnt_q <= cnt_q - 1;
    end
  end

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected walk computed from the requirements
  task automatic model(input logic [31:0] va, input bit wr, input bit usr,
                       output logic [1:0] f, output logic [31:0] pa,
                       output logic [31:0] ent, output int n,
                       output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] e1;
    a1 = TBL + {20'h0, va[31:22], 2'b00};
    e1 = rd(a1);
    pa = '0;
    a2 = '0;
    if (!e1[0]) begin
      f = 2'd1; ent = e1; n = 1;
    end else begin
      n   = 2;
      a2  = {e1[31:13], 13'h0} + {21'h0, va[21:13], 2'b00};
      ent = rd(a2);
      if (!ent[0]) f = 2'd2;
      else if ((wr && !ent[3]) || (usr && !ent[4])) f = 2'd3;
      else begin f = 2'd0; pa = {ent[31:13], va[12:0]}; end
    end
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input bit usr,
                      input bit poke_busy);
    logic [1:0] ef; logic [31:0] epa, ent, a1, a2;
    int en, snap, waited;
    model(va, wr, usr, ef, epa, ent, en, a1, a2);
    snap = rd_total;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_vaddr = ~va; req_write = ~wr;
    req_valid = poke_busy;
    if (poke_busy) chk(req_ready == 1'b0, "R8 busy ready", 32'(req_ready), 0);
    waited = 0;
    while (!done && waited < 200) begin @(negedge clk); waited++; end
    req_valid = 1'b0;
    chk(done == 1'b1, "R10 done seen", 32'(done), 1);
    chk(done_fault == ef, "R4 R5 R6 fault", 32'(done_fault), 32'(ef));
    chk(done_paddr == epa, "R1 R7 paddr", done_paddr, epa);
    chk({done_frame, done_prot, done_dirty, done_ref} == {ent[31:13], ent[4:1]},
        "R7 fields", {done_frame, 9'h0, done_prot, done_dirty, done_ref},
        {ent[31:13], 9'h0, ent[4:1]});
    chk(rd_total - snap == en, "R4 R8 read count", 32'(rd_total - snap), 32'(en));
    if (en == 1) chk(rd_last == a1, "R2 first addr", rd_last, a1);
    else begin
      chk(rd_prev == a1, "R2 first addr", rd_prev, a1);
      chk(rd_last == a2, "R3 second addr", rd_last, a2);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 single pulse", 32'(done), 0);
  endtask

  function automatic logic [31:0] mk(input logic [18:0] fr, input logic [1:0] acc,
                                     input bit d, input bit r, input bit v);
    return {fr, 8'h00, acc, d, r, v};
  endfunction

  task automatic ensure(input logic [31:0] va);
    logic [31:0] a1, a2;
    a1 = TBL + {20'h0, va[31:22], 2'b00};
    if (!pmem.exists(a1)) begin
      if ($urandom % 100 < 85)
        pmem[a1] = mk(19'h100 + 19'(va[31:22]), 2'($urandom), 1'($urandom), 1'($urandom), 1'b1);
      else
        pmem[a1] = mk(19'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    end
    if (pmem[a1][0]) begin
      a2 = {pmem[a1][31:13], 13'h0} + {21'h0, va[21:13], 2'b00};
      if (!pmem.exists(a2))
        pmem[a2] = mk(19'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      ($urandom % 100) < 80);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] va;
    int unsigned seed_sink;
    seed_sink = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0, "R9 in reset",
        {29'h0, req_ready, mem_req, done}, 32'h4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0, "R9 after reset",
        {29'h0, req_ready, mem_req, done}, 32'h4);

    // directed corner cases
    pmem[TBL + 32'd4]    = mk(19'h0AAAA, 2'b11, 1'b1, 1'b1, 1'b0); // absent L1
    walk({10'd1, 9'd5, 13'h0123}, 1'b1, 1'b1, 1'b0);                 // R4
    pmem[TBL + 32'd8]    = mk(19'h00200, 2'b00, 1'b0, 1'b0, 1'b1);  // L1 no rights
    pmem[32'h0040_0000 + 32'd12] = mk(19'h12345, 2'b11, 1'b1, 1'b0, 1'b1);
    walk({10'd2, 9'd3, 13'h1ABC}, 1'b1, 1'b1, 1'b0);                 // R6 L1 bits ignored
    pmem[32'h0040_0000 + 32'd16] = mk(19'h00777, 2'b11, 1'b0, 1'b1, 1'b0);
    walk({10'd2, 9'd4, 13'h0001}, 1'b0, 1'b0, 1'b0);                 // R5
    pmem[32'h0040_0000 + 32'd20] = mk(19'h00321, 2'b10, 1'b1, 1'b1, 1'b1);
    walk({10'd2, 9'd5, 13'h0010}, 1'b1, 1'b0, 1'b0);                 // R6 write denied
    walk({10'd2, 9'd5, 13'h0010}, 1'b0, 1'b1, 1'b0);                 // R1 read ok
    pmem[32'h0040_0000 + 32'd24] = mk(19'h00654, 2'b01, 1'b0, 1'b0, 1'b1);
    walk({10'd2, 9'd6, 13'h0020}, 1'b0, 1'b1, 1'b0);                 // R6 user denied
    pmem[TBL + 32'hFFC]  = mk(19'h7FFFE, 2'b11, 1'b1, 1'b1, 1'b1);
    pmem[{19'h7FFFE, 13'h0} + 32'h7FC] = mk(19'h7FFFF, 2'b11, 1'b1, 1'b1, 1'b1);
    walk(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);                           // R1 R3 R8 top
    walk({10'd2, 9'd5, 13'h1FFF}, 1'b0, 1'b0, 1'b1);                 // R8 busy poke

    // constrained random walks
    for (int i = 0; i < 160; i++) begin
      lat = 1 + ($urandom % 4);
      va  = $urandom;
      if ($urandom % 4 != 0) va[31:22] = 10'($urandom % 12);
      ensure(va);
      walk(va, 1'($urandom), 1'($urandom), ($urandom % 8) == 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule